// File: doc/BRIEF.md
# Battery Charge Sequencing Controller

This block decides when an external current-limited charger may push current into a battery cell. It drives two active-low gates. The recovery gate lets a reduced trickle current reach a deeply discharged cell. The fast gate passes the full charger current. The block takes periodic voltage and temperature samples, a charger-present flag and host strobes. From these it runs a full charge sequence: initiation, hold-off until conditions are safe, and a lithium bulk phase followed by a pulse phase that ends on a measured decay time. It also applies secondary terminations on temperature and elapsed time.

All time constants are clock-cycle parameters, so a real deployment uses large prescale values and a simulation uses small ones. A NiMH cell is terminated by a one-cycle pulse from an external temperature-slope detector. A two-bit status summarises the sequence, and its completion code stays set until the host acknowledges it.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset both `rcv_n` and `fast_n` are 1 and `chg_status` is 2'b00.
- R2: When no completion is latched, `chg_status` reads 2'b01 while fast charging or while recovery is active. Otherwise it reads 2'b10 if the charger is present and 2'b00 if it is absent. All of these values appear one cycle after the inputs that cause them.
- R3: Completion sets `chg_status` to 2'b11, and it holds there until a `stat_wr` strobe. If a completion and a `stat_wr` fall in the same cycle, the completion wins.
- R4: A `start_cmd` strobe initiates a charge. A rising edge of `src_present` also initiates one when `cfg_auto` is 1. A charger appearing while `cfg_auto` is 0 starts nothing.
- R5: After initiation, fast charge waits while any of these is true: the temperature lies outside [T_LO, T_HI], the charger is absent, a sample is invalid, or the voltage is below V_LB. Fast charge begins on the first cycle in which none of these holds.
- R6: `rcv_n` goes low one cycle after the charger is present with a valid voltage below V_LB. It returns high once the voltage reaches V_LB.
- R7: During fast charge, `fast_n` is forced high for the last PROBE_HIGH cycles of every PROBE_PERIOD-cycle window. The window is counted from fast-charge entry.
- R8: In lithium mode, the gate stays on until the voltage reaches V_CV. It then alternates between an on-time of PULSE_LOW cycles and an off-time that lasts until the voltage falls below V_CV.
- R9: A lithium charge completes when one off-time reaches DECAY_PERIODS*PULSE_LOW cycles without the voltage falling below V_CV.
- R10: During fast charge, a temperature above T_MAX completes the charge. A charge-time count of zero also completes it.
- R11: The charge-time count loads from `ct_preset` at fast-charge entry and decrements once every CT_TICK fast-charge cycles. A `ct_wr` strobe overwrites it at any time.
- R12: Each of these aborts to idle with both gates high and no completion latched: `stop_cmd`, charger removal, or `bus_low_long` while `cfg_auto` is 0. `bus_low_long` is ignored while `cfg_auto` is 1.
- R13: In NiMH mode (`cfg_nimh`=1), the V_CV threshold is ignored and a `nimh_term` pulse completes the charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| volt_smp | input | VW | Cell voltage sample, unsigned |
| volt_vld | input | 1 | Voltage sample valid |
| temp_smp | input | TW | Temperature sample, signed, 0.125 degree units |
| temp_vld | input | 1 | Temperature sample valid |
| src_present | input | 1 | Charger present |
| cfg_nimh | input | 1 | 1 selects NiMH, 0 selects lithium |
| cfg_auto | input | 1 | Allow initiation on charger arrival |
| start_cmd | input | 1 | Start strobe |
| stop_cmd | input | 1 | Stop strobe |
| bus_low_long | input | 1 | Long host-bus-low event |
| stat_wr | input | 1 | Status write strobe, clears completion |
| ct_preset | input | CT_W | Charge-time load value |
| ct_wr | input | 1 | Charge-time overwrite strobe |
| ct_wdata | input | CT_W | Charge-time overwrite value |
| nimh_term | input | 1 | NiMH slope termination pulse |
| rcv_n | output | 1 | Recovery gate, active low |
| fast_n | output | 1 | Fast-charge gate, active low |
| chg_status | output | 2 | Charge status code |
| ct_remain | output | CT_W | Remaining charge-time count |

## Verification
Two events can land in the same cycle: the lithium decay-limit completion, which sets the latched code, and a host status write, which clears it. The bench runs a full pulse phase whose decay cycle it has counted in advance. It raises `stat_wr` exactly on the edge where the final decay cycle ends. It then expects 2'b11 to survive that edge and the following idle cycles, and expects a later lone write to return the status to 2'b10.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PEND  = 3'd1,
      ST_BULK  = 3'd2,
      ST_PON   = 3'd3,
      ST_DECAY = 3'd4
   } chg_state_e;

   typedef enum logic [1:0] {
      CS_NOSRC = 2'b00,
      CS_BUSY  = 2'b01,
      CS_SRC   = 2'b10,
      CS_DONE  = 2'b11
   } chg_stat_e;
endpackage

// File: rtl/chg_qual.sv
module chg_qual #(
   parameter int VW    = 10,
   parameter int TW    = 11,
   parameter int V_LB  = 615,
   parameter int V_CV  = 861,
   parameter int T_LO  = 0,
   parameter int T_HI  = 320,
   parameter int T_MAX = 400
) (
   input  logic                 volt_vld,
   input  logic [VW-1:0]        volt_smp,
   input  logic                 temp_vld,
   input  logic signed [TW-1:0] temp_smp,
   output logic                 low_batt,
   output logic                 cv_reached,
   output logic                 cv_below,
   output logic                 temp_in_win,
   output logic                 temp_hot
);
   localparam logic [VW-1:0]        VLB_C = VW'(V_LB);
   localparam logic [VW-1:0]        VCV_C = VW'(V_CV);
   localparam logic signed [TW-1:0] TLO_C = TW'(T_LO);
   localparam logic signed [TW-1:0] THI_C = TW'(T_HI);
   localparam logic signed [TW-1:0] TMX_C = TW'(T_MAX);

   assign low_batt    = volt_vld && (volt_smp < VLB_C);
   assign cv_reached  = volt_vld && (volt_smp >= VCV_C);
   assign cv_below    = volt_vld && (volt_smp < VCV_C);
   assign temp_in_win = temp_vld && (temp_smp >= TLO_C) && (temp_smp <= THI_C);
   assign temp_hot    = temp_vld && (temp_smp > TMX_C);
endmodule

// File: rtl/chg_ct_timer.sv
module chg_ct_timer #(
   parameter int CT_W    = 8,
   parameter int CT_TICK = 50
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            en,
   input  logic [CT_W-1:0] preset,
   input  logic            wr,
   input  logic [CT_W-1:0] wdata,
   output logic [CT_W-1:0] ct,
   output logic            zero
);
   logic            tick;
   logic [CT_W-1:0] ct_q;

   generate
      if (CT_TICK < 1) begin : g_bad_tick
         $error("chg_ct_timer: CT_TICK must be at least 1");
      end
      if (CT_TICK > 1) begin : g_pre
         localparam int PSW = $clog2(CT_TICK);
         localparam logic [PSW-1:0] PS_LAST = PSW'(CT_TICK - 1);
         logic [PSW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (load)   pre_q <= '0;
            else if (en)     pre_q <= (pre_q == PS_LAST) ? '0 : pre_q + 1'b1;
         end
         assign tick = en && !load && (pre_q == PS_LAST);
      end else begin : g_nopre
         assign tick = en && !load;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ct_q <= '0;
      else if (wr)                     ct_q <= wdata;
      else if (load)                   ct_q <= preset;
      else if (tick && (ct_q != '0))   ct_q <= ct_q - 1'b1;
   end

   assign ct   = ct_q;
   assign zero = (ct_q == '0);
endmodule

// File: rtl/chg_probe_gen.sv
module chg_probe_gen #(
   parameter int PROBE_PERIOD = 8,
   parameter int PROBE_HIGH   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic probe_hi
);
   generate
      if (PROBE_PERIOD < 2) begin : g_bad_period
         $error("chg_probe_gen: PROBE_PERIOD must be at least 2");
      end
      if (PROBE_HIGH == 0) begin : g_noprobe
         assign probe_hi = 1'b0;
      end else begin : g_probe
         localparam int PRW = $clog2(PROBE_PERIOD);
         localparam logic [PRW-1:0] PR_LAST = PRW'(PROBE_PERIOD - 1);
         localparam logic [PRW-1:0] PR_HIGH_AT = PRW'(PROBE_PERIOD - PROBE_HIGH);
         logic [PRW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (clr)  cnt_q <= '0;
            else if (en)   cnt_q <= (cnt_q == PR_LAST) ? '0 : cnt_q + 1'b1;
         end
         assign probe_hi = en && (cnt_q >= PR_HIGH_AT);
      end
   endgenerate
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
   import chg_seq_pkg::*;
#(
   parameter int VW            = 10,
   parameter int TW            = 11,
   parameter int CT_W          = 8,
   parameter int V_LB          = 615,
   parameter int V_CV          = 861,
   parameter int T_LO          = 0,
   parameter int T_HI          = 320,
   parameter int T_MAX         = 400,
   parameter int PROBE_PERIOD  = 8,
   parameter int PROBE_HIGH    = 4,
   parameter int PULSE_LOW     = 6,
   parameter int DECAY_PERIODS = 15,
   parameter int CT_TICK       = 50
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VW-1:0]        volt_smp,
   input  logic                 volt_vld,
   input  logic signed [TW-1:0] temp_smp,
   input  logic                 temp_vld,
   input  logic                 src_present,
   input  logic                 cfg_nimh,
   input  logic                 cfg_auto,
   input  logic                 start_cmd,
   input  logic                 stop_cmd,
   input  logic                 bus_low_long,
   input  logic                 stat_wr,
   input  logic [CT_W-1:0]      ct_preset,
   input  logic                 ct_wr,
   input  logic [CT_W-1:0]      ct_wdata,
   input  logic                 nimh_term,
   output logic                 rcv_n,
   output logic                 fast_n,
   output logic [1:0]           chg_status,
   output logic [CT_W-1:0]      ct_remain
);
   localparam int DECAY_CYC = DECAY_PERIODS * PULSE_LOW;
   localparam int PHW       = $clog2(DECAY_CYC + 1);
   localparam logic [PHW-1:0] PON_LAST = PHW'(PULSE_LOW - 1);
   localparam logic [PHW-1:0] DEC_LAST = PHW'(DECAY_CYC - 1);

   generate
      if (PROBE_HIGH >= PROBE_PERIOD) begin : g_bad_probe
         $error("chg_seq_ctrl: PROBE_HIGH must be below PROBE_PERIOD");
      end
      if (PULSE_LOW < 1 || DECAY_PERIODS < 1) begin : g_bad_pulse
         $error("chg_seq_ctrl: pulse timing parameters must be positive");
      end
      if (V_CV <= V_LB) begin : g_bad_volt
         $error("chg_seq_ctrl: V_CV must exceed V_LB");
      end
   endgenerate

   chg_state_e     state_q, state_d;
   logic [PHW-1:0] phase_q, phase_d;
   logic           done_q, rcv_q, src_q;
   logic           fast_start, finish;
   logic           low_batt, cv_reached, cv_below, temp_in_win, temp_hot;
   logic           ct_zero, probe_hi;
   logic           in_fast, gate_on, abort, init, ready, sec_term, chem_term;

   chg_qual #(
      .VW(VW), .TW(TW), .V_LB(V_LB), .V_CV(V_CV),
      .T_LO(T_LO), .T_HI(T_HI), .T_MAX(T_MAX)
   ) u_qual (
      .volt_vld   (volt_vld),
      .volt_smp   (volt_smp),
      .temp_vld   (temp_vld),
      .temp_smp   (temp_smp),
      .low_batt   (low_batt),
      .cv_reached (cv_reached),
      .cv_below   (cv_below),
      .temp_in_win(temp_in_win),
      .temp_hot   (temp_hot)
   );

   chg_ct_timer #(.CT_W(CT_W), .CT_TICK(CT_TICK)) u_ct (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fast_start),
      .en    (in_fast),
      .preset(ct_preset),
      .wr    (ct_wr),
      .wdata (ct_wdata),
      .ct    (ct_remain),
      .zero  (ct_zero)
   );

   chg_probe_gen #(.PROBE_PERIOD(PROBE_PERIOD), .PROBE_HIGH(PROBE_HIGH)) u_probe (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fast_start),
      .en      (in_fast),
      .probe_hi(probe_hi)
   );

   assign in_fast   = (state_q == ST_BULK) || (state_q == ST_PON) || (state_q == ST_DECAY);
   assign gate_on   = (state_q == ST_BULK) || (state_q == ST_PON);
   assign abort     = stop_cmd || (bus_low_long && !cfg_auto);
   assign init      = start_cmd || (cfg_auto && src_present && !src_q);
   assign ready     = src_present && temp_in_win && volt_vld && !low_batt;
   assign sec_term  = temp_hot || ct_zero;
   assign chem_term = cfg_nimh && nimh_term;

   always_comb begin
      state_d    = state_q;
      phase_d    = phase_q;
      fast_start = 1'b0;
      finish     = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (init && !abort) state_d = ST_PEND;
         end
         ST_PEND: begin
            if (abort) begin
               state_d = ST_IDLE;
            end else if (ready) begin
               state_d    = ST_BULK;
               fast_start = 1'b1;
            end
         end
         ST_BULK, ST_PON, ST_DECAY: begin
            if (abort || !src_present) begin
               state_d = ST_IDLE;
            end else if (sec_term || chem_term) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
            end else begin
               case (state_q)
                  ST_BULK: begin
                     if (!cfg_nimh && cv_reached) begin
                        state_d = ST_PON;
                        phase_d = '0;
                     end
                  end
                  ST_PON: begin
                     if (phase_q == PON_LAST) begin
                        state_d = ST_DECAY;
                        phase_d = '0;
                     end else begin
                        phase_d = phase_q + 1'b1;
                     end
                  end
                  ST_DECAY: begin
                     if (cv_below) begin
                        state_d = ST_PON;
                        phase_d = '0;
                     end else if (phase_q == DEC_LAST) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                     end else begin
                        phase_d = phase_q + 1'b1;
                     end
                  end
                  default: state_d = ST_IDLE;
               endcase
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= '0;
         done_q  <= 1'b0;
         rcv_q   <= 1'b0;
         src_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         rcv_q   <= src_present && low_batt;
         src_q   <= src_present;
         if (finish)       done_q <= 1'b1;
         else if (stat_wr) done_q <= 1'b0;
      end
   end

   always_comb begin
      if (done_q)                chg_status = CS_DONE;
      else if (in_fast || rcv_q) chg_status = CS_BUSY;
      else if (src_q)            chg_status = CS_SRC;
      else                       chg_status = CS_NOSRC;
   end

   assign rcv_n  = !rcv_q;
   assign fast_n = !(gate_on && !probe_hi);
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk #(
   parameter int VW    = 10,
   parameter int TW    = 11,
   parameter int V_LB  = 615,
   parameter int T_MAX = 400
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [VW-1:0]        volt_smp,
   input logic                 volt_vld,
   input logic signed [TW-1:0] temp_smp,
   input logic                 temp_vld,
   input logic                 src_present,
   input logic                 cfg_nimh,
   input logic                 stop_cmd,
   input logic                 stat_wr,
   input logic                 nimh_term,
   input logic                 rcv_n,
   input logic                 fast_n,
   input logic [1:0]           chg_status
);
   localparam logic [VW-1:0]        LB_C = VW'(V_LB);
   localparam logic signed [TW-1:0] TM_C = TW'(T_MAX);

   // R6
   rcv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_present && volt_vld && volt_smp < LB_C) |=> !rcv_n);

   // R3
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_status == 2'b11 && !stat_wr) |=> chg_status == 2'b11);

   // R12
   stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> fast_n);

   // R5
   src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_n |-> $past(src_present));

   // R10
   hot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_n && temp_vld && temp_smp > TM_C) |=> (fast_n && chg_status == 2'b11));

   // R13
   nimh_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_n && cfg_nimh && nimh_term) |=> fast_n);
endmodule

bind chg_seq_ctrl chg_seq_chk #(
   .VW(VW), .TW(TW), .V_LB(V_LB), .T_MAX(T_MAX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .volt_smp   (volt_smp),
   .volt_vld   (volt_vld),
   .temp_smp   (temp_smp),
   .temp_vld   (temp_vld),
   .src_present(src_present),
   .cfg_nimh   (cfg_nimh),
   .stop_cmd   (stop_cmd),
   .stat_wr    (stat_wr),
   .nimh_term  (nimh_term),
   .rcv_n      (rcv_n),
   .fast_n     (fast_n),
   .chg_status (chg_status)
);

// File: tb/tb_chg_seq_ctrl.sv
module tb_chg_seq_ctrl;
   localparam int VW = 10, TW = 11, CT_W = 8;
   localparam int V_LB = 615, V_CV = 861, T_LO = 0, T_HI = 320, T_MAX = 400;
   localparam int PROBE_PERIOD = 8, PROBE_HIGH = 4, PULSE_LOW = 6;
   localparam int DECAY_PERIODS = 15, CT_TICK = 50;
   localparam int DECAY_CYC = DECAY_PERIODS * PULSE_LOW;

   // {src, volt_vld, volt[9:0], exp_rcv_n, exp_status[1:0]}
   localparam logic [14:0] VEC [6] = '{
      {1'b0, 1'b1, 10'd700, 1'b1, 2'b00},
      {1'b1, 1'b1, 10'd700, 1'b1, 2'b10},
      {1'b1, 1'b1, 10'd500, 1'b0, 2'b01},
      {1'b1, 1'b1, 10'd615, 1'b1, 2'b10},
      {1'b0, 1'b1, 10'd500, 1'b1, 2'b00},
      {1'b1, 1'b0, 10'd500, 1'b1, 2'b10}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [VW-1:0] volt_smp = 10'd700;
   logic volt_vld = 1'b1, temp_vld = 1'b1;
   logic signed [TW-1:0] temp_smp = 11'sd200;
   logic src_present = 0, cfg_nimh = 0, cfg_auto = 0, start_cmd = 0, stop_cmd = 0;
   logic bus_low_long = 0, stat_wr = 0, ct_wr = 0, nimh_term = 0;
   logic [CT_W-1:0] ct_preset = 8'd200, ct_wdata = 8'd0;
   logic rcv_n, fast_n;
   logic [1:0] chg_status;
   logic [CT_W-1:0] ct_remain;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   chg_seq_ctrl #(
      .VW(VW), .TW(TW), .CT_W(CT_W), .V_LB(V_LB), .V_CV(V_CV), .T_LO(T_LO),
      .T_HI(T_HI), .T_MAX(T_MAX), .PROBE_PERIOD(PROBE_PERIOD), .PROBE_HIGH(PROBE_HIGH),
      .PULSE_LOW(PULSE_LOW), .DECAY_PERIODS(DECAY_PERIODS), .CT_TICK(CT_TICK)
   ) dut (
      .clk(clk), .rst_n(rst_n), .volt_smp(volt_smp), .volt_vld(volt_vld),
      .temp_smp(temp_smp), .temp_vld(temp_vld), .src_present(src_present),
      .cfg_nimh(cfg_nimh), .cfg_auto(cfg_auto), .start_cmd(start_cmd),
      .stop_cmd(stop_cmd), .bus_low_long(bus_low_long), .stat_wr(stat_wr),
      .ct_preset(ct_preset), .ct_wr(ct_wr), .ct_wdata(ct_wdata),
      .nimh_term(nimh_term), .rcv_n(rcv_n), .fast_n(fast_n),
      .chg_status(chg_status), .ct_remain(ct_remain)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_start();
      start_cmd = 1'b1; tick(); start_cmd = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_cmd = 1'b1; tick(); stop_cmd = 1'b0;
   endtask

   task automatic pulse_clear();
      stat_wr = 1'b1; tick(); stat_wr = 1'b0;
   endtask

   task automatic count_lows(input int n, output int lows);
      lows = 0;
      for (int i = 0; i < n; i++) begin
         if (!fast_n) lows++;
         tick();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lows;
      bit all_hi;
      @(negedge clk); @(negedge clk);
      // R1 reset state
      check(rcv_n && fast_n && chg_status == 2'b00, "R1 reset", {rcv_n, fast_n, chg_status}, 6'b110000);
      rst_n = 1'b1;
      tick();

      // R2/R6/R4 vector table, auto initiation off
      for (int v = 0; v < 6; v++) begin
         src_present = VEC[v][14];
         volt_vld    = VEC[v][13];
         volt_smp    = VEC[v][12:3];
         ticks(2);
         check(rcv_n == VEC[v][2] && chg_status == VEC[v][1:0] && fast_n,
               "R2 R6 R4 vector", {rcv_n, chg_status}, {VEC[v][2], VEC[v][1:0]});
      end

      // R5 hold-off on cold temperature
      src_present = 1; volt_vld = 1; volt_smp = 700; temp_smp = -11'sd8;
      ticks(2);
      pulse_start();
      ticks(3);
      check(fast_n && chg_status == 2'b10, "R5 cold hold", {fast_n, chg_status}, 3'b110);
      temp_smp = 11'sd200;
      tick();
      check(!fast_n && chg_status == 2'b01, "R5 release", {fast_n, chg_status}, 3'b001);
      // R7 probe window
      lows = 0;
      for (int i = 0; i < PROBE_PERIOD; i++) begin
         tick();
         if (!fast_n) lows++;
      end
      check(lows == PROBE_PERIOD - PROBE_HIGH, "R7 probe", lows, PROBE_PERIOD - PROBE_HIGH);
      // R12 stop
      pulse_stop();
      check(fast_n && chg_status == 2'b10, "R12 stop", {fast_n, chg_status}, 3'b110);

      // R5 invalid sample hold-off
      volt_vld = 0;
      pulse_start();
      ticks(2);
      check(fast_n && chg_status == 2'b10, "R5 invalid hold", {fast_n, chg_status}, 3'b110);
      volt_vld = 1;
      tick();
      check(!fast_n, "R5 valid release", fast_n, 0);
      pulse_stop();

      // R6 recovery then fast
      volt_smp = 500;
      pulse_start();
      tick();
      check(!rcv_n && fast_n && chg_status == 2'b01, "R6 recovery", {rcv_n, fast_n, chg_status}, 4'b0101);
      volt_smp = 700;
      tick();
      check(rcv_n && !fast_n, "R6 recovery end", {rcv_n, fast_n}, 2'b10);
      pulse_stop();

      // R8 R9 lithium pulse phase, R3 simultaneous completion and write
      pulse_start();
      tick();
      volt_smp = 870;
      tick();
      count_lows(PULSE_LOW, lows);
      check(lows >= 2, "R8 on-time", lows, 2);
      all_hi = 1;
      for (int i = 0; i < 10; i++) begin
         if (!fast_n || chg_status != 2'b01) all_hi = 0;
         tick();
      end
      check(all_hi, "R8 off-time", all_hi, 1);
      volt_smp = 800;
      tick();
      volt_smp = 870;
      count_lows(PULSE_LOW, lows);
      check(lows >= 2, "R8 repeat", lows, 2);
      all_hi = 1;
      for (int i = 0; i < DECAY_CYC - 1; i++) begin
         if (!fast_n || chg_status != 2'b01) all_hi = 0;
         tick();
      end
      check(all_hi && chg_status == 2'b01, "R9 decay window", chg_status, 1);
      stat_wr = 1;
      tick();
      stat_wr = 0;
      check(chg_status == 2'b11 && fast_n, "R9 R3 completion wins", chg_status, 3);
      ticks(3);
      check(chg_status == 2'b11, "R3 latched", chg_status, 3);
      pulse_clear();
      check(chg_status == 2'b10, "R3 cleared", chg_status, 2);
      volt_smp = 700;

      // R10 R11 charge-time expiry
      ct_preset = 2;
      pulse_start();
      tick();
      check(ct_remain == 2, "R11 load", ct_remain, 2);
      ticks(90);
      check(chg_status == 2'b01, "R11 running", chg_status, 1);
      ticks(12);
      check(chg_status == 2'b11 && fast_n, "R10 time expiry", chg_status, 3);
      pulse_clear();

      // R11 host overwrite
      pulse_start();
      tick();
      ticks(9);
      ct_wdata = 200; ct_wr = 1;
      tick();
      ct_wr = 0;
      ticks(140);
      check(chg_status == 2'b01, "R11 overwrite", chg_status, 1);
      pulse_stop();
      ct_preset = 200;

      // R10 over-temperature
      pulse_start();
      tick();
      temp_smp = 11'sd408;
      tick();
      check(chg_status == 2'b11 && fast_n, "R10 hot", chg_status, 3);
      temp_smp = 11'sd200;
      pulse_clear();

      // R13 NiMH
      cfg_nimh = 1;
      pulse_start();
      tick();
      volt_smp = 870;
      tick();
      count_lows(PROBE_PERIOD, lows);
      check(lows == PROBE_PERIOD - PROBE_HIGH, "R13 ignores V_CV", lows, PROBE_PERIOD - PROBE_HIGH);
      nimh_term = 1;
      tick();
      nimh_term = 0;
      check(chg_status == 2'b11 && fast_n, "R13 slope end", chg_status, 3);
      pulse_clear();
      cfg_nimh = 0;
      volt_smp = 700;

      // R12 source removal
      pulse_start();
      tick();
      src_present = 0;
      tick();
      check(fast_n && chg_status == 2'b00, "R12 removal", {fast_n, chg_status}, 3'b100);

      // R4 auto initiation, R12 bus-low ignored / honoured
      cfg_auto = 1; src_present = 1;
      ticks(2);
      check(!fast_n && chg_status == 2'b01, "R4 auto start", {fast_n, chg_status}, 3'b001);
      bus_low_long = 1; tick(); bus_low_long = 0;
      check(chg_status == 2'b01, "R12 bus-low ignored", chg_status, 1);
      cfg_auto = 0;
      bus_low_long = 1; tick(); bus_low_long = 0;
      check(fast_n && chg_status == 2'b10, "R12 bus-low abort", {fast_n, chg_status}, 3'b110);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule